// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address of every beat of a four-word burst, starting from one externally supplied base address. Each enabled clock edge does one of two things. It either captures a fresh base address, which starts a new burst, or it steps the internal beat counter by one. Only the two least significant address bits move while a burst runs. The upper bits keep the value captured with the base for all beats.

A static order input chooses how the low bits travel. In linear order they count upward from the starting offset and wrap within the four-word block. In interleaved order they are the starting offset XOR-ed with the beat index. A clock-enable input stalls the sequencer: when it is low, the edge changes no state.

The command input, the order input and the clock enable are plain control pins. The block has no data path and no handshake. The current address and the beat index come straight from registered state, so they appear one edge after the command that caused them.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the address output and the beat index to zero. Reset overrides every other input.
- R2: At an edge with clk_en high and adv_ld low (load), the block captures ext_addr as the base. After that edge, addr_o equals ext_addr and beat_o is 0. This holds even when the load comes in the middle of a burst.
- R3: With interleave low (linear order), addr_o[1:0] equals (base[1:0] + beat_o) mod 4. For example, a start offset of 2 gives the sequence 2, 3, 0, 1.
- R4: With interleave high (interleaved order), addr_o[1:0] equals base[1:0] XOR beat_o. For example, a start offset of 1 gives the sequence 1, 0, 3, 2. The order pin selects the mapping for the current beat without a clock edge.
- R5: Inside a burst, addr_o[18:2] keeps the loaded upper bits. A wrap of the low bits never carries into them.
- R6: At an edge with clk_en high and adv_ld high (advance), beat_o increments. An advance from beat 3 returns to beat 0, so the address is again the first address of the same burst.
- R7: At an edge with clk_en low, the base and the beat index hold their values, whatever adv_ld and ext_addr are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; low stalls all state |
| adv_ld | input | 1 | 0 = load a new base, 1 = advance one beat |
| interleave | input | 1 | Static order select: 0 = linear, 1 = interleaved |
| ext_addr | input | 19 | External base address, captured on load |
| addr_o | output | 19 | Address of the current beat |
| beat_o | output | 2 | Index of the current beat within the burst |

## Verification
Linear bursts are run from start offset 2 and from offset 3 with all upper bits set. These patterns separate a true modulo-4 wrap from a carry into the upper bits. An interleaved burst from offset 1 is used because XOR and addition differ at that offset; from offset 2 the two orders give the same sequence and would hide a swapped mapping. Further patterns cover:
- stalls that arrive together with load and advance commands, which show that disabled edges are ignored;
- a load in the middle of a burst, which must clear the beat index;
- a reset in the middle of a burst;
- a change of the order pin between edges, which checks that the mapping changes with no edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    CMD_LOAD    = 1'b0,
    CMD_ADVANCE = 1'b1
  } step_cmd_e;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  step_cmd_e         cmd,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] base_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (clk_en && cmd == CMD_LOAD) begin
      base_q <= ext_addr;
    end
  end

  // R2
  base_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && cmd == CMD_LOAD) |=> (base_q == $past(ext_addr)));

  // R7
  base_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en) |=> $stable(base_q));

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  step_cmd_e         cmd,
  output logic [BEAT_W-1:0] beat_q
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
    end else if (clk_en) begin
      if (cmd == CMD_LOAD) beat_q <= '0;
      else                 beat_q <= beat_q + BEAT_W'(1);
    end
  end

  // R6
  beat_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && cmd == CMD_ADVANCE && beat_q == LAST_BEAT) |=> (beat_q == '0));

  // R2
  load_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && cmd == CMD_LOAD) |=> (beat_q == '0));

  // R7
  beat_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en) |=> $stable(beat_q));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] lo_out
);

  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  // Linear order: add and drop the carry, so the wrap stays inside the block.
  assign lin_lo = start_lo + beat;

  // Interleaved order: each low bit flips with the matching beat bit.
  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
    assign ilv_lo[b] = start_lo[b] ^ beat[b];
  end

  always_comb begin
    unique case (order)
      ORDER_INTERLEAVE: lo_out = ilv_lo;
      default:          lo_out = lin_lo;
    endcase
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              adv_ld,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  step_cmd_e         cmd;
  burst_order_e      order;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] lo_addr;

  assign cmd   = step_cmd_e'(adv_ld);
  assign order = burst_order_e'(interleave);

  burst_base_reg #(.ADDR_W(ADDR_W)) i_base (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .cmd      (cmd),
    .ext_addr (ext_addr),
    .base_q   (base_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) i_beat (
    .clk    (clk),
    .rst    (rst),
    .clk_en (clk_en),
    .cmd    (cmd),
    .beat_q (beat_q)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) i_map (
    .start_lo (base_q[BEAT_W-1:0]),
    .beat     (beat_q),
    .order    (order),
    .lo_out   (lo_addr)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], lo_addr};
  assign beat_o = beat_q;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && beat_o == '0));

  // R5
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv_ld) |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv_ld && !interleave) ##1 (!interleave) |->
      (addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + BEAT_W'(1))));

  // R4
  ilv_step_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv_ld && interleave) ##1 interleave |->
      ((addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) == (beat_o ^ $past(beat_o))));

  // Keeps UPPER_W in use as a sanity bound on the parameters.
  initial begin
    upper_width_chk: assert (UPPER_W > 0);
  end

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int AW = 19;
  localparam int BW = 2;

  typedef struct packed {
    logic          en;
    logic          adv;
    logic          ilv;
    logic [AW-1:0] ext;
    logic [AW-1:0] exp_addr;
    logic [BW-1:0] exp_beat;
  } vec_t;

  localparam int NVEC = 17;
  // Each row is one edge: inputs, then the outputs expected after that edge.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b0, 19'h12346, 19'h12346, 2'd0}, // R2 load, start offset 2
    '{1'b1, 1'b1, 1'b0, 19'h00000, 19'h12347, 2'd1}, // R3
    '{1'b1, 1'b1, 1'b0, 19'h00000, 19'h12344, 2'd2}, // R3 wrap of the low bits
    '{1'b1, 1'b1, 1'b0, 19'h00000, 19'h12345, 2'd3}, // R3
    '{1'b1, 1'b1, 1'b0, 19'h00000, 19'h12346, 2'd0}, // R6 back to the first address
    '{1'b0, 1'b0, 1'b0, 19'h7FFFF, 19'h12346, 2'd0}, // R7 load ignored while stalled
    '{1'b0, 1'b1, 1'b0, 19'h00000, 19'h12346, 2'd0}, // R7 advance ignored while stalled
    '{1'b1, 1'b0, 1'b1, 19'h0ABC5, 19'h0ABC5, 2'd0}, // R2 load, start offset 1
    '{1'b1, 1'b1, 1'b1, 19'h00000, 19'h0ABC4, 2'd1}, // R4
    '{1'b1, 1'b1, 1'b1, 19'h00000, 19'h0ABC7, 2'd2}, // R4
    '{1'b1, 1'b1, 1'b1, 19'h00000, 19'h0ABC6, 2'd3}, // R4
    '{1'b1, 1'b1, 1'b1, 19'h00000, 19'h0ABC5, 2'd0}, // R6 interleaved wrap
    '{1'b1, 1'b1, 1'b1, 19'h00000, 19'h0ABC4, 2'd1}, // R4
    '{1'b1, 1'b0, 1'b0, 19'h7FFFF, 19'h7FFFF, 2'd0}, // R2 load in mid burst
    '{1'b1, 1'b1, 1'b0, 19'h00000, 19'h7FFFC, 2'd1}, // R5 no carry upward
    '{1'b0, 1'b1, 1'b0, 19'h00000, 19'h7FFFC, 2'd1}, // R7
    '{1'b1, 1'b1, 1'b0, 19'h00000, 19'h7FFFD, 2'd2}  // R5
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en = 1'b0;
  logic          adv_ld = 1'b0;
  logic          interleave = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] addr_o;
  logic [BW-1:0] beat_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) i_burst_addr_seq (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .adv_ld     (adv_ld),
    .interleave (interleave),
    .ext_addr   (ext_addr),
    .addr_o     (addr_o),
    .beat_o     (beat_o)
  );

  task automatic check(input string req, input logic [AW-1:0] exp_a, input logic [BW-1:0] exp_b);
    n_checks++;
    if (addr_o !== exp_a || beat_o !== exp_b) begin
      n_fails++;
      $display("FAIL %s: actual addr=%h beat=%0d, expected addr=%h beat=%0d",
               req, addr_o, beat_o, exp_a, exp_b);
    end
  endtask

  task automatic step(input logic en, input logic adv, input logic ilv, input logic [AW-1:0] ext);
    clk_en     = en;
    adv_ld     = adv;
    interleave = ilv;
    ext_addr   = ext;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", 19'h00000, 2'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].en, VECS[i].adv, VECS[i].ilv, VECS[i].ext);
      check($sformatf("vector %0d (R2 R3 R4 R5 R6 R7)", i), VECS[i].exp_addr, VECS[i].exp_beat);
    end

    // R1: reset in the middle of a burst, with load requested.
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b0, 19'h55555);
    check("R1 mid-burst reset", 19'h00000, 2'd0);
    rst = 1'b0;

    // R4: the order pin remaps the current beat without an edge.
    step(1'b1, 1'b0, 1'b0, 19'h00001);
    step(1'b1, 1'b1, 1'b0, 19'h00000);
    check("R3 linear beat 1 from offset 1", 19'h00002, 2'd1);
    interleave = 1'b1;
    #1;
    check("R4 order switch between edges", 19'h00000, 2'd1);
    step(1'b1, 1'b1, 1'b1, 19'h00000);
    check("R4 interleaved beat 2 from offset 1", 19'h00003, 2'd2);

    // R6: a further wrap lands on the start address of the same burst.
    step(1'b1, 1'b1, 1'b1, 19'h00000);
    step(1'b1, 1'b1, 1'b1, 19'h00000);
    check("R6 wrap to start", 19'h00001, 2'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual still running, expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule